// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block chooses which of N interrupt sources is presented to a CPU. Each source supplies a pending line, an enable bit and a priority bit; a bit value of 1 selects the high level and 0 the low level. A global enable gates every source. Each cycle the block registers the pending lines that are eligible, decodes them, and raises one vector request. The request carries the index of the winning source.

The block records which priority levels have a handler running in two in-service bits, low and high. A CPU-side acknowledge accepts the request. It sets the in-service bit for the winner's level and sends a one-cycle acknowledge pulse to that source only, which lets the source clear its edge flag. A return indication clears the highest in-service level. A small state machine then blocks new requests until the CPU reports that one more instruction has completed. A stall input holds requests back while the CPU cannot take a vector.

The state machine has two states. `ST_ARB` is the state in which a request may be raised. `ST_HOLD` is the post-return gap. The transition `ST_ARB -> ST_HOLD` occurs on a return indication, which takes effect from either state. The transition `ST_HOLD -> ST_ARB` occurs on the instruction-complete input when no return is present in the same cycle. Every other case stays in the current state.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `req_o` is 0, `src_ack_o` is all zero, both in-service bits are clear and the state is `ST_ARB`.
- R2: A source takes part only when its pending bit, its enable bit and `glob_en_i` are all 1. Otherwise it never produces a request.
- R3: Inputs are registered once before decoding. A change on the pending, enable, priority or global-enable inputs shows on `req_o`/`vec_o` one clock later.
- R4: A high-level candidate (priority bit 1) wins over any low-level candidate. Within one level, the lowest index wins. `vec_o` gives the winner's binary index.
- R5: When `ack_i` is 1 while `req_o` is 1, `src_ack_o` has exactly bit `vec_o` set for the following single cycle.
- R6: While only the low in-service bit is set, only a high-level winner raises `req_o`. A low-level winner is held back.
- R7: While the high in-service bit is set, `req_o` stays 0.
- R8: `reti_i` clears the high in-service bit if it is set, and otherwise clears the low one. From the next cycle on, `req_o` stays 0 until `insn_done_i` has been seen.
- R9: While `stall_i` is 1, `req_o` is 0.
- R10: `ack_i` while `req_o` is 0 has no effect. No acknowledge pulse is sent and the in-service state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | N | Pending line of each source |
| en_i | input | N | Per-source enable |
| prio_hi_i | input | N | Per-source priority, 1 = high |
| glob_en_i | input | 1 | Global enable of all sources |
| stall_i | input | 1 | CPU stalled, no request may be raised |
| ack_i | input | 1 | CPU accepts the current vector |
| reti_i | input | 1 | CPU returns from a handler |
| insn_done_i | input | 1 | CPU finished one instruction |
| req_o | output | 1 | Vector request to the CPU |
| vec_o | output | $clog2(N) | Index of the winning source |
| src_ack_o | output | N | One-cycle acknowledge to the chosen source |

## Verification
The two functions that can coincide are preemption and blocking. A high-level request can arrive while a low-level handler is running and a low-level source is still pending. The bench sets up this case by acknowledging a low source, keeping it pending, and then raising a high source. It expects the request to appear for the high index only, while the low one stays hidden. A second collision occurs when a request is pending at the moment of a return. The bench expects `req_o` to stay low through the gap, and then to name the correct winner one cycle after the instruction-complete pulse.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic {
        ST_ARB  = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_t;

    localparam int LVL_LO = 0;
    localparam int LVL_HI = 1;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand_i,
    output logic            vld_o,
    output logic [IDXW-1:0] idx_o
);
    always_comb begin
        vld_o = |cand_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pend_i,
    input  logic [N-1:0]    en_i,
    input  logic [N-1:0]    prio_hi_i,
    input  logic            glob_en_i,
    input  logic            stall_i,
    input  logic            ack_i,
    input  logic            reti_i,
    input  logic            insn_done_i,
    output logic            req_o,
    output logic [IDXW-1:0] vec_o,
    output logic [N-1:0]    src_ack_o
);
    localparam int NLVL = 2;

    arb_state_t        state_q, state_d;
    logic [N-1:0]      samp_pend_q;
    logic [N-1:0]      samp_prio_q;
    logic [NLVL-1:0]   in_svc_q, in_svc_d;
    logic [N-1:0]      src_ack_q, src_ack_d;

    logic [N-1:0]      lvl_set [NLVL];
    logic [NLVL-1:0]   lvl_vld;
    logic [IDXW-1:0]   lvl_idx [NLVL];

    logic              win_vld, win_hi, win_ok, take;
    logic [IDXW-1:0]   win_idx;
    logic [NLVL-1:0]   clr_mask, set_mask;

    // detection stage: one register between the pins and the decoder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_pend_q <= '0;
            samp_prio_q <= '0;
        end else begin
            samp_pend_q <= pend_i & en_i & {N{glob_en_i}};
            samp_prio_q <= prio_hi_i;
        end
    end

    assign lvl_set[LVL_LO] = samp_pend_q & ~samp_prio_q;
    assign lvl_set[LVL_HI] = samp_pend_q &  samp_prio_q;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        irq_pick #(.N(N), .IDXW(IDXW)) u_pick (
            .cand_i (lvl_set[g]),
            .vld_o  (lvl_vld[g]),
            .idx_o  (lvl_idx[g])
        );
    end

    assign win_hi  = lvl_vld[LVL_HI];
    assign win_vld = |lvl_vld;
    assign win_idx = win_hi ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
    assign win_ok  = win_vld && !in_svc_q[LVL_HI] && (win_hi || !in_svc_q[LVL_LO]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ARB;
            in_svc_q  <= '0;
            src_ack_q <= '0;
        end else begin
            state_q   <= state_d;
            in_svc_q  <= in_svc_d;
            src_ack_q <= src_ack_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_o     = 1'b0;
        clr_mask  = '0;
        set_mask  = '0;
        src_ack_d = '0;
        unique case (state_q)
            ST_ARB: begin
                req_o = win_ok && !stall_i;
                if (reti_i) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (reti_i)           state_d = ST_HOLD;
                else if (insn_done_i) state_d = ST_ARB;
            end
            default: state_d = ST_ARB;
        endcase
        take = req_o && ack_i;
        if (reti_i) begin
            if (in_svc_q[LVL_HI])      clr_mask[LVL_HI] = 1'b1;
            else if (in_svc_q[LVL_LO]) clr_mask[LVL_LO] = 1'b1;
        end
        if (take) begin
            set_mask[win_hi ? LVL_HI : LVL_LO] = 1'b1;
            src_ack_d = {{(N-1){1'b0}}, 1'b1} << win_idx;
        end
        in_svc_d = (in_svc_q & ~clr_mask) | set_mask;
    end

    assign vec_o     = win_idx;
    assign src_ack_o = src_ack_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall_i,
    input logic            ack_i,
    input logic            reti_i,
    input logic            req_o,
    input logic [IDXW-1:0] vec_o,
    input logic [N-1:0]    src_ack_o,
    input logic [1:0]      in_svc
);
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !req_o);

    p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack_o));

    p_ack_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_o) |=> (src_ack_o == ({{(N-1){1'b0}}, 1'b1} << $past(vec_o))));

    p_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_i && req_o)) |=> (src_ack_o == '0));

    p_hi_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |-> !req_o);

    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !req_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(.N(N), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_i   (stall_i),
    .ack_i     (ack_i),
    .reti_i    (reti_i),
    .req_o     (req_o),
    .vec_o     (vec_o),
    .src_ack_o (src_ack_o),
    .in_svc    (in_svc_q)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
    localparam int N    = 8;
    localparam int IDXW = 3;
    localparam int NV   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    pend = '0, en = '0, prio = '0;
    logic            glob = 1'b0, stall = 1'b0, ack = 1'b0, reti = 1'b0, done = 1'b0;
    logic            req;
    logic [IDXW-1:0] vec;
    logic [N-1:0]    sack;
    int              checks = 0, errors = 0;
    bit              finished = 1'b0;

    always #10 clk = ~clk;

    irq_arbiter #(.N(N), .IDXW(IDXW)) i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_hi_i(prio),
        .glob_en_i(glob), .stall_i(stall), .ack_i(ack), .reti_i(reti),
        .insn_done_i(done), .req_o(req), .vec_o(vec), .src_ack_o(sack)
    );

    // {pend, en, prio, glob, exp_req, exp_vec}
    localparam logic [28:0] VT [NV] = '{
        {8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h24, 8'hFF, 8'h00, 1'b1, 1'b1, 3'd2},
        {8'h24, 8'hFF, 8'h20, 1'b1, 1'b1, 3'd5},
        {8'hA0, 8'hFF, 8'hA0, 1'b1, 1'b1, 3'd5},
        {8'h0C, 8'h08, 8'h00, 1'b1, 1'b1, 3'd3},
        {8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0},
        {8'h81, 8'hFF, 8'h80, 1'b1, 1'b1, 3'd7},
        {8'h81, 8'h7E, 8'h00, 1'b1, 1'b0, 3'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_req(input string tag, input bit er, input int ev);
        chk(req == er && (!er || vec == IDXW'(ev)), tag, {req, vec}, {er, 3'(ev)});
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_return();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        chk(req == 1'b0 && sack == '0, "R1 reset outputs", {req, sack}, 0);
        rst_n = 1'b1;
        step();

        // table walk: R2 R3 R4
        for (int k = 0; k < NV; k++) begin
            pend = VT[k][28:21]; en = VT[k][20:13]; prio = VT[k][12:5]; glob = VT[k][4];
            step();
            chk_req($sformatf("R2/R3/R4 vector %0d", k), VT[k][3], int'(VT[k][2:0]));
        end

        // R5 and R6: acknowledge a low source, then preempt with high
        pend = 8'h02; en = 8'hFF; prio = 8'h00; glob = 1'b1;
        step();
        chk_req("R3 low source 1 request", 1'b1, 1);
        pulse_ack();
        chk(sack == 8'h02, "R5 pulse to source 1", sack, 8'h02);
        chk_req("R6 low blocked under low handler", 1'b0, 0);
        step();
        chk(sack == 8'h00, "R5 pulse lasts one cycle", sack, 0);
        pend = 8'h42; prio = 8'h40;
        step();
        chk_req("R6 high preempts low", 1'b1, 6);
        pulse_ack();
        chk(sack == 8'h40, "R5 pulse to source 6", sack, 8'h40);
        pend = 8'h12; prio = 8'h10;
        step();
        chk_req("R7 high handler not preempted", 1'b0, 0);

        // R8: return with a high request pending
        do_return();
        chk_req("R8 gap after return", 1'b0, 0);
        step();
        chk_req("R8 gap holds without insn done", 1'b0, 0);
        done = 1'b1; step(); done = 1'b0;
        chk_req("R8 request after insn done", 1'b1, 4);

        // R9 stall
        stall = 1'b1;
        #1;
        chk_req("R9 stall hides request", 1'b0, 0);
        // R10 ack while no request
        ack = 1'b1; step(); ack = 1'b0;
        chk(sack == 8'h00, "R10 ack ignored no pulse", sack, 0);
        stall = 1'b0;
        #1;
        chk_req("R10 state unchanged after ignored ack", 1'b1, 4);

        // R8 return clears highest level only
        step();
        pulse_ack();
        pend = 8'h02; prio = 8'h00;
        do_return();
        done = 1'b1; step(); done = 1'b0;
        chk_req("R8 low level still in service", 1'b0, 0);
        do_return();
        done = 1'b1; step(); done = 1'b0;
        chk_req("R8 both levels cleared", 1'b1, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule